// File: doc/BRIEF.md
# Flash Sector-Erase Command Sequencer

This block models the command state machine of a parallel NOR flash device, limited to the sector-erase path. It watches bus writes, each completed on the rising edge of an active-low write strobe. It recognises the six-write sequence that arms a sector erase. It then keeps an acceptance window open in which more sectors may be added to an erase bitmap. When the window lapses, it runs a timed erase of every marked sector.

Time is counted in microsecond ticks from an external prescaler. Each selected sector is first driven to all zeros and then erased, lowest index first, and its bitmap bit is cleared when it finishes. The memory array and the erase physics are not modelled; fixed tick counts stand in for them. The sequencer is meant to sit behind a flash bus model, so that a host-side driver can be checked against the command timing rules.

Top module: `flash_sector_erase_seq`

## Requirements
- R1: While and after hardware reset (`hw_rst_n` low, asynchronous) the outputs are: `mode` = 0, `busy` = 0, `window_expired` = 0 and `sector_map` = 0.
- R2: A write completes on a rising edge of `we_n`. The arming sequence is six writes, where the unlock address compares `addr[10:0]`: 0x555/0xAA, then 0x2AA/0x55, then 0x555/0x80, then 0x555/0xAA, then 0x2AA/0x55, then any address with data 0x30. The sixth write opens the window: `mode` = 1 (accepting), `busy` = 1, and `sector_map` holds only bit `addr[13:11]`.
- R3: A write that does not match the next expected step of the arming sequence returns the sequencer to read-array mode (`mode` = 0) with an empty bitmap.
- R4: While the window is open, each write with data 0x30 sets bit `addr[13:11]` in `sector_map`. Sectors may be added in any order, and each such write restarts the window count.
- R5: The window closes after 50 `us_tick` pulses with no accepted write. Erasing then starts: `window_expired` = 1, `busy` = 1 and `mode` = 2.
- R6: A write in the window whose data is neither 0x30 nor 0xB0 aborts the operation: `mode` = 0, `busy` = 0 and `sector_map` = 0.
- R7: A write with data 0xB0 (suspend code) in the window or during erasing neither aborts the operation nor changes `sector_map`.
- R8: Once erasing has started, every write is ignored: no bitmap bit is added and the mode is not disturbed.
- R9: Sectors are processed lowest index first. Each sector spends 4 ticks in the zeroing phase (`mode` = 2), then 6 ticks in the erase phase (`mode` = 3), and its bit then clears.
- R10: After the last sector clears, the sequencer is in read-array mode (`mode` = 0, `busy` = 0, `window_expired` = 0). A lone write with data 0x30 then sets no bitmap bit.
- R11: Asserting hardware reset during erasing ends the operation at once, with `mode` = 0 and `sector_map` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low; a write completes on its rising edge |
| addr | input | 14 | Bus address; bits 13:11 select the sector |
| data | input | 8 | Bus write data (command code) |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| busy | output | 1 | High while the window is open or erasing is in progress |
| sector_map | output | 8 | One bit per sector still to be erased |
| window_expired | output | 1 | High once the window has closed and erasing is under way |
| mode | output | 2 | 0 read array, 1 accepting sectors, 2 zeroing, 3 erasing |

## Verification
Some rules are checked by properties on every cycle: the bitmap never gains a bit once erasing runs, the window never shows an empty bitmap, the erase phase is always reached through the zeroing phase, a foreign write in the window always empties the map, and the sixth arming write always yields a one-hot map. Other behaviour only the bench scenarios can show: the exact tick on which the window closes after a restart, the tick counts of each phase, the ascending sector order, the dropped partial sequences, and the reset cutting an erase short.

// File: rtl/flash_se_pkg.sv
package flash_se_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UL1,
        ST_UL2,
        ST_SETUP,
        ST_UL3,
        ST_UL4,
        ST_WINDOW,
        ST_ERASE
    } seq_state_e;

    typedef enum logic [2:0] {
        WR_UNLOCK_A,
        WR_UNLOCK_B,
        WR_SETUP,
        WR_SECTOR,
        WR_SUSPEND,
        WR_OTHER
    } wr_class_e;

    localparam logic [1:0] MODE_READ   = 2'd0;
    localparam logic [1:0] MODE_ACCEPT = 2'd1;
    localparam logic [1:0] MODE_ZERO   = 2'd2;
    localparam logic [1:0] MODE_ERASE  = 2'd3;

endpackage

// File: rtl/flash_se_bus_decode.sv
module flash_se_bus_decode
    import flash_se_pkg::*;
#(
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CMD_ADDR_W = 11,
    parameter int unsigned UL_ADDR_A  = 'h555,
    parameter int unsigned UL_DATA_A  = 'hAA,
    parameter int unsigned UL_ADDR_B  = 'h2AA,
    parameter int unsigned UL_DATA_B  = 'h55,
    parameter int unsigned SETUP_CODE = 'h80,
    parameter int unsigned SE_CODE    = 'h30,
    parameter int unsigned SUSP_CODE  = 'hB0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              wr_evt,
    output wr_class_e         wr_cls
);

    logic                  we_n_q;
    logic [CMD_ADDR_W-1:0] low_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_n_q <= 1'b1;
        else        we_n_q <= we_n;
    end

    assign wr_evt   = !we_n_q && we_n;
    assign low_addr = addr[CMD_ADDR_W-1:0];

    always_comb begin
        if (data == DATA_W'(SE_CODE))
            wr_cls = WR_SECTOR;
        else if (data == DATA_W'(SUSP_CODE))
            wr_cls = WR_SUSPEND;
        else if (low_addr == CMD_ADDR_W'(UL_ADDR_A) && data == DATA_W'(UL_DATA_A))
            wr_cls = WR_UNLOCK_A;
        else if (low_addr == CMD_ADDR_W'(UL_ADDR_B) && data == DATA_W'(UL_DATA_B))
            wr_cls = WR_UNLOCK_B;
        else if (low_addr == CMD_ADDR_W'(UL_ADDR_A) && data == DATA_W'(SETUP_CODE))
            wr_cls = WR_SETUP;
        else
            wr_cls = WR_OTHER;
    end

endmodule

// File: rtl/flash_se_lowest_set.sv
module flash_se_lowest_set #(
    parameter int unsigned N     = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    assign any = |vec;

endmodule

// File: rtl/flash_sector_erase_seq.sv
module flash_sector_erase_seq
    import flash_se_pkg::*;
#(
    parameter int unsigned NUM_SECTORS = 8,
    parameter int unsigned ADDR_W      = 14,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CMD_ADDR_W  = 11,
    parameter int unsigned WINDOW_US   = 50,
    parameter int unsigned PREP_US     = 4,
    parameter int unsigned ERASE_US    = 6,
    parameter int unsigned UL_ADDR_A   = 'h555,
    parameter int unsigned UL_DATA_A   = 'hAA,
    parameter int unsigned UL_ADDR_B   = 'h2AA,
    parameter int unsigned UL_DATA_B   = 'h55,
    parameter int unsigned SETUP_CODE  = 'h80,
    parameter int unsigned SE_CODE     = 'h30,
    parameter int unsigned SUSP_CODE   = 'hB0
) (
    input  logic                   clk,
    input  logic                   hw_rst_n,
    input  logic                   we_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      data,
    input  logic                   us_tick,
    output logic                   busy,
    output logic [NUM_SECTORS-1:0] sector_map,
    output logic                   window_expired,
    output logic [1:0]             mode
);

    localparam int unsigned SEC_W   = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;
    localparam int unsigned MAX_A   = (WINDOW_US > PREP_US) ? WINDOW_US : PREP_US;
    localparam int unsigned CNT_MAX = (MAX_A > ERASE_US) ? MAX_A : ERASE_US;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e             st;
        logic [NUM_SECTORS-1:0] map;
        logic [CNT_W-1:0]       cnt;
        logic                   zeroing;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic                   wr_evt;
    wr_class_e              wr_cls;
    logic [SEC_W-1:0]       sec_idx;
    logic [NUM_SECTORS-1:0] sec_bit;
    logic [SEC_W-1:0]       pick_idx;
    logic                   pick_any;
    logic [NUM_SECTORS-1:0] map_left;

    flash_se_bus_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR_W(CMD_ADDR_W),
        .UL_ADDR_A(UL_ADDR_A), .UL_DATA_A(UL_DATA_A),
        .UL_ADDR_B(UL_ADDR_B), .UL_DATA_B(UL_DATA_B),
        .SETUP_CODE(SETUP_CODE), .SE_CODE(SE_CODE), .SUSP_CODE(SUSP_CODE)
    ) u_decode (
        .clk(clk), .rst_n(hw_rst_n), .we_n(we_n), .addr(addr), .data(data),
        .wr_evt(wr_evt), .wr_cls(wr_cls)
    );

    flash_se_lowest_set #(.N(NUM_SECTORS)) u_pick (
        .vec(cur_q.map), .idx(pick_idx), .any(pick_any)
    );

    assign sec_idx  = addr[ADDR_W-1 -: SEC_W];
    assign sec_bit  = NUM_SECTORS'(1) << sec_idx;
    assign map_left = cur_q.map & ~(NUM_SECTORS'(1) << pick_idx);

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_READ:  if (wr_evt && wr_cls == WR_UNLOCK_A) nxt_d.st = ST_UL1;
            ST_UL1:   if (wr_evt) nxt_d.st = (wr_cls == WR_UNLOCK_B) ? ST_UL2   : ST_READ;
            ST_UL2:   if (wr_evt) nxt_d.st = (wr_cls == WR_SETUP)    ? ST_SETUP : ST_READ;
            ST_SETUP: if (wr_evt) nxt_d.st = (wr_cls == WR_UNLOCK_A) ? ST_UL3   : ST_READ;
            ST_UL3:   if (wr_evt) nxt_d.st = (wr_cls == WR_UNLOCK_B) ? ST_UL4   : ST_READ;
            ST_UL4: begin
                if (wr_evt) begin
                    if (wr_cls == WR_SECTOR) begin
                        nxt_d.st  = ST_WINDOW;
                        nxt_d.map = sec_bit;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.st = ST_READ;
                    end
                end
            end
            ST_WINDOW: begin
                if (wr_evt) begin
                    if (wr_cls == WR_SECTOR) begin
                        nxt_d.map = cur_q.map | sec_bit;
                        nxt_d.cnt = '0;
                    end else if (wr_cls != WR_SUSPEND) begin
                        nxt_d.st  = ST_READ;
                        nxt_d.map = '0;
                        nxt_d.cnt = '0;
                    end
                end else if (us_tick) begin
                    if (cur_q.cnt == CNT_W'(WINDOW_US - 1)) begin
                        nxt_d.st      = ST_ERASE;
                        nxt_d.cnt     = '0;
                        nxt_d.zeroing = 1'b1;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            ST_ERASE: begin
                if (us_tick && pick_any) begin
                    if (cur_q.zeroing) begin
                        if (cur_q.cnt == CNT_W'(PREP_US - 1)) begin
                            nxt_d.zeroing = 1'b0;
                            nxt_d.cnt     = '0;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + 1'b1;
                        end
                    end else if (cur_q.cnt == CNT_W'(ERASE_US - 1)) begin
                        nxt_d.map     = map_left;
                        nxt_d.cnt     = '0;
                        nxt_d.zeroing = (map_left != '0);
                        if (map_left == '0) nxt_d.st = ST_READ;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            default: nxt_d.st = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) cur_q <= '{st: ST_READ, map: '0, cnt: '0, zeroing: 1'b0};
        else           cur_q <= nxt_d;
    end

    assign sector_map     = cur_q.map;
    assign busy           = (cur_q.st == ST_WINDOW) || (cur_q.st == ST_ERASE);
    assign window_expired = (cur_q.st == ST_ERASE);
    always_comb begin
        if (cur_q.st == ST_WINDOW)     mode = MODE_ACCEPT;
        else if (cur_q.st == ST_ERASE) mode = cur_q.zeroing ? MODE_ZERO : MODE_ERASE;
        else                           mode = MODE_READ;
    end

    AST_ENTER_WINDOW: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (cur_q.st == ST_UL4 && wr_evt && wr_cls == WR_SECTOR)
        |=> (mode == MODE_ACCEPT && $countones(sector_map) == 1)); // R2
    AST_WINDOW_NONEMPTY: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (mode == MODE_ACCEPT) |-> (sector_map != '0)); // R4
    AST_EXPIRED_BUSY: assert property (@(posedge clk) disable iff (!hw_rst_n)
        window_expired |-> (busy && sector_map != '0)); // R5
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (cur_q.st == ST_WINDOW && wr_evt && wr_cls != WR_SECTOR && wr_cls != WR_SUSPEND)
        |=> (mode == MODE_READ && sector_map == '0 && !busy)); // R6
    AST_SUSPEND_INERT: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (busy && wr_evt && wr_cls == WR_SUSPEND && !us_tick) |=> $stable(sector_map)); // R7
    AST_NO_GROWTH: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (cur_q.st == ST_ERASE) |=> ((sector_map & ~$past(sector_map)) == '0)); // R8
    AST_ZERO_FIRST: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (mode == MODE_ERASE) |-> ($past(mode) == MODE_ZERO || $past(mode) == MODE_ERASE)); // R9

endmodule

// File: tb/flash_sector_erase_seq_test.sv
module flash_sector_erase_seq_test;

    logic        clk = 1'b0;
    logic        hw_rst_n = 1'b0;
    logic        we_n = 1'b1;
    logic [13:0] addr = '0;
    logic [7:0]  data = '0;
    logic        us_tick = 1'b0;
    logic        busy;
    logic [7:0]  sector_map;
    logic        window_expired;
    logic [1:0]  mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    flash_sector_erase_seq uut (
        .clk(clk), .hw_rst_n(hw_rst_n), .we_n(we_n), .addr(addr), .data(data),
        .us_tick(us_tick), .busy(busy), .sector_map(sector_map),
        .window_expired(window_expired), .mode(mode)
    );

    typedef struct packed {
        logic [13:0] a;
        logic [7:0]  d;
        logic [1:0]  m;
        logic [7:0]  map;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VEC [14] = '{
        '{14'h0555, 8'hAA, 2'd0, 8'h00, 8'd2},  // R2 step 1
        '{14'h02AA, 8'h55, 2'd0, 8'h00, 8'd2},
        '{14'h0555, 8'h80, 2'd0, 8'h00, 8'd2},
        '{14'h0555, 8'hAA, 2'd0, 8'h00, 8'd2},
        '{14'h02AA, 8'h55, 2'd0, 8'h00, 8'd2},
        '{14'h1800, 8'h30, 2'd1, 8'h08, 8'd2},  // R2 sector 3 arms window
        '{14'h3000, 8'h30, 2'd1, 8'h48, 8'd4},  // R4 add sector 6
        '{14'h0000, 8'hB0, 2'd1, 8'h48, 8'd7},  // R7 suspend inert
        '{14'h0800, 8'h30, 2'd1, 8'h4A, 8'd4},  // R4 add sector 1
        '{14'h0123, 8'hF0, 2'd0, 8'h00, 8'd6},  // R6 abort
        '{14'h02AA, 8'h55, 2'd0, 8'h00, 8'd3},  // R3 out of order
        '{14'h0555, 8'hAA, 2'd0, 8'h00, 8'd3},
        '{14'h0555, 8'h80, 2'd0, 8'h00, 8'd3},  // R3 mismatch drops sequence
        '{14'h1000, 8'h30, 2'd0, 8'h00, 8'd3}   // R3 no window opened
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; data = d; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); us_tick = 1'b1;
            @(negedge clk); us_tick = 1'b0;
        end
    endtask

    task automatic arm(input logic [2:0] sec);
        wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr(14'h0555, 8'h80);
        wr(14'h0555, 8'hAA); wr(14'h02AA, 8'h55); wr({sec, 11'h000}, 8'h30);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        #1;
        chk("R1 mode in reset", 32'(mode), 0);
        chk("R1 busy/expired/map in reset", {busy, window_expired, sector_map}, 0);
        repeat (3) @(negedge clk);
        hw_rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode after reset", 32'(mode), 0);

        for (int i = 0; i < 14; i++) begin
            wr(VEC[i].a, VEC[i].d);
            chk($sformatf("R%0d vec %0d mode", VEC[i].req, i), 32'(mode), 32'(VEC[i].m));
            chk($sformatf("R%0d vec %0d map", VEC[i].req, i), 32'(sector_map), 32'(VEC[i].map));
        end

        // R4/R5: window restart and expiry
        arm(3'd5);
        chk("R2 busy in window", 32'(busy), 1);
        ticks(49);
        chk("R5 still accepting after 49 ticks", 32'(mode), 1);
        wr(14'h1000, 8'h30);
        chk("R4 sector 2 added", 32'(sector_map), 32'h24);
        ticks(49);
        chk("R4 restart keeps window open", {window_expired, mode}, {1'b0, 2'd1});
        ticks(1);
        chk("R5 expired at 50th tick", {busy, window_expired, mode}, {1'b1, 1'b1, 2'd2});

        // R8/R7: writes during erasing
        wr(14'h3800, 8'h30);
        chk("R8 no sector added", 32'(sector_map), 32'h24);
        wr(14'h0123, 8'hF0);
        chk("R8 foreign write ignored", {busy, mode}, {1'b1, 2'd2});
        wr(14'h0000, 8'hB0);
        chk("R7 suspend in erase inert", {mode, sector_map}, {2'd2, 8'h24});

        // R9: phase lengths and ascending order
        ticks(3);
        chk("R9 zeroing lasts 4 ticks", 32'(mode), 2);
        ticks(1);
        chk("R9 erase phase begins", 32'(mode), 3);
        ticks(5);
        chk("R9 sector 2 still pending", {mode, sector_map}, {2'd3, 8'h24});
        ticks(1);
        chk("R9 lowest sector cleared first", {mode, sector_map}, {2'd2, 8'h20});
        ticks(4);
        chk("R9 second sector erase phase", 32'(mode), 3);
        ticks(6);
        chk("R10 back to read", {busy, window_expired, mode, sector_map}, 0);
        wr(14'h0800, 8'h30);
        chk("R10 lone command not latched", {mode, sector_map}, 0);

        // R11: reset during erasing
        arm(3'd4);
        ticks(50);
        chk("R11 erasing before reset", {mode, sector_map}, {2'd2, 8'h10});
        ticks(2);
        @(negedge clk);
        hw_rst_n = 1'b0;
        #1;
        chk("R11 reset ends erase at once", {busy, window_expired, mode, sector_map}, 0);
        @(negedge clk);
        hw_rst_n = 1'b1;
        @(negedge clk);
        chk("R11 stays in read", 32'(mode), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule